// File: doc/BRIEF.md
# Page Coherence Directory Engine

This block is the home-node directory for a group of memory pages under software-managed, release-consistent coherence. Each page entry records a base coherence state, a learned safe/unsafe flag, a bitmap of the processors that map the page, a bitmap of the processors that hold write access, and two small history counters. Events arrive one at a time, tagged with a page number and a processor ID: a read fault, a write fault, or an acquire-time check. The engine updates the entry in the cycle the event is accepted. When a page newly becomes weak it may owe write notices to the other mappers. In that case it issues them one per cycle through a valid/ready port and holds off further events until the last notice has been taken. Serial processing of one event at a time stands in for a per-entry lock.

Pages that keep turning weak stop costing notices. Once a safe page has sent notices on enough weak transitions, it is marked unsafe. Its later weak transitions then cost nothing, and processors discover its state through their acquire checks instead. If an unsafe page is checked often enough while not weak, it goes back to safe. Both thresholds come from configuration inputs, which would normally hold 4. A combinational look-up port shows the base state, flag and mapper set of any page.

Top module: `pcd_engine`

## Requirements
- R1: After reset is released, which takes two clock edges to synchronise, ev_ready is 1 and ntc_valid and chk_valid are 0. Every page reads base UNCACHED, is safe, and has no mappers.
- R2: ev_kind encodes 0 as read fault, 1 as write fault and 2 or 3 as acquire. look_base encodes UNCACHED as 0, SHARED as 1, DIRTY as 2 and WEAK as 3. A read or write fault adds the requester to the mappers; a write fault on a mapped page also adds it to the writers. The result is SHARED if there are no writers, DIRTY if there is exactly one mapper and a writer, and WEAK otherwise.
- R3: A write fault on an UNCACHED page moves it to SHARED, with the requester recorded as a mapper but not as a writer.
- R4: When a safe page enters WEAK and its notice count is below notice_lim, one notice goes to every mapper other than the requester. Notices are issued in ascending processor ID order, and the notice count rises by one.
- R5: While any notice of the current event is outstanding, ev_ready is 0 and no event is accepted.
- R6: When a safe page enters WEAK and its notice count is at or above notice_lim, the page becomes unsafe, no notice is sent, and the notice count is cleared.
- R7: When an unsafe page enters WEAK, no notice is sent.
- R8: chk_valid is 1 for exactly the cycle after an acquire is accepted. chk_inval is then 1 if and only if the page was WEAK and unsafe when the acquire was accepted.
- R9: An acquire on a WEAK page removes the requester from the mappers and writers. The page becomes UNCACHED if no mappers remain and otherwise stays WEAK.
- R10: An acquire on an unsafe page that is not WEAK raises its check count by one. If the count was already at or above check_lim, the page instead returns to safe and the count is cleared.
- R11: While ntc_valid is 1 and ntc_ready is 0, ntc_valid stays 1 and ntc_proc does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| notice_lim | input | CW (4) | Notice-sending weak transitions allowed before a page turns unsafe |
| check_lim | input | CW (4) | Unneeded checks allowed before an unsafe page turns safe |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Engine can accept an event |
| ev_kind | input | 2 | 0 read fault, 1 write fault, 2/3 acquire |
| ev_page | input | PG_W (3) | Page index |
| ev_proc | input | PID_W (2) | Requesting processor |
| ntc_valid | output | 1 | Write notice pending |
| ntc_ready | input | 1 | Notice taken this cycle |
| ntc_proc | output | PID_W (2) | Target processor of the notice |
| chk_valid | output | 1 | Acquire response present |
| chk_inval | output | 1 | 1 invalidate, 0 keep |
| look_page | input | PG_W (3) | Page to observe |
| look_base | output | 2 | Base state of look_page |
| look_unsafe | output | 1 | Unsafe flag of look_page |
| look_mappers | output | NP (4) | Mapper bitmap of look_page |

## Verification
Directed sequences walk one page through repeated weak cycles. They cover reader pairs followed by a writer (notices while safe), the transition that makes the page unsafe, a weak entry that sends nothing, and then acquires on the unsafe page until it relaxes back to safe. Together these separate the notice path from the learning path. A second page starts from a write to an unmapped page, which separates the deferred-write rule from a plain write. A back-pressured notice phase shows that events block and the target stays stable. A long random phase mixes kinds, pages, processors and notice back-pressure against a behavioural model, which reaches mapper-removal and mixed reader/writer orderings that the directed cases do not.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  typedef enum logic [1:0] {
    PG_UNC  = 2'd0,
    PG_SHR  = 2'd1,
    PG_DRT  = 2'd2,
    PG_WEAK = 2'd3
  } pg_base_e;

  localparam logic [1:0] KIND_RD = 2'd0;
  localparam logic [1:0] KIND_WR = 2'd1;

endpackage

// File: rtl/pcd_next.sv
module pcd_next
  import pcd_pkg::*;
#(
  parameter int NP = 4,
  parameter int CW = 4,
  localparam int PID_W = (NP > 1) ? $clog2(NP) : 1
) (
  input  pg_base_e          cur_base,
  input  logic              cur_unsafe,
  input  logic [NP-1:0]     cur_sh,
  input  logic [NP-1:0]     cur_wr,
  input  logic [CW-1:0]     cur_nc,
  input  logic [CW-1:0]     cur_cc,
  input  logic [1:0]        kind,
  input  logic [PID_W-1:0]  proc,
  input  logic [CW-1:0]     nlim,
  input  logic [CW-1:0]     clim,
  output pg_base_e          nxt_base,
  output logic              nxt_unsafe,
  output logic [NP-1:0]     nxt_sh,
  output logic [NP-1:0]     nxt_wr,
  output logic [CW-1:0]     nxt_nc,
  output logic [CW-1:0]     nxt_cc,
  output logic [NP-1:0]     ntc_mask,
  output logic              acq_inval
);

  logic [NP-1:0] req_bit;
  logic [NP-1:0] sh_a;
  logic [NP-1:0] wr_a;
  pg_base_e      base_a;
  logic          is_acq;
  logic          is_wr;

  always_comb begin
    req_bit    = NP'(1) << proc;
    is_acq     = kind[1];
    is_wr      = (kind == KIND_WR);
    sh_a       = cur_sh;
    wr_a       = cur_wr;
    base_a     = cur_base;
    nxt_unsafe = cur_unsafe;
    nxt_nc     = cur_nc;
    nxt_cc     = cur_cc;
    ntc_mask   = '0;
    acq_inval  = 1'b0;

    if (!is_acq) begin
      sh_a = cur_sh | req_bit;
      // a write to an unmapped page is only a mapping until the next release
      if (is_wr && (cur_base != PG_UNC)) begin
        wr_a = cur_wr | req_bit;
      end
      if (wr_a == '0) begin
        base_a = PG_SHR;
      end else if ($onehot(sh_a)) begin
        base_a = PG_DRT;
      end else begin
        base_a = PG_WEAK;
      end
      if ((base_a == PG_WEAK) && (cur_base != PG_WEAK) && !cur_unsafe) begin
        if (cur_nc >= nlim) begin
          nxt_unsafe = 1'b1;
          nxt_nc     = '0;
        end else begin
          ntc_mask = sh_a & ~req_bit;
          nxt_nc   = cur_nc + CW'(1);
        end
      end
    end else begin
      acq_inval = (cur_base == PG_WEAK) && cur_unsafe;
      if (cur_base == PG_WEAK) begin
        sh_a = cur_sh & ~req_bit;
        wr_a = cur_wr & ~req_bit;
        if (sh_a == '0) begin
          base_a = PG_UNC;
          wr_a   = '0;
        end
      end else if (cur_unsafe) begin
        if (cur_cc >= clim) begin
          nxt_unsafe = 1'b0;
          nxt_cc     = '0;
        end else begin
          nxt_cc = cur_cc + CW'(1);
        end
      end
    end

    nxt_base = base_a;
    nxt_sh   = sh_a;
    nxt_wr   = wr_a;
  end

endmodule

// File: rtl/pcd_table.sv
module pcd_table #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  parameter int PW    = 7,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd,
  input  logic [AW-1:0] pa,
  output logic [PW-1:0] pd
);

  logic [W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic [W-1:0] row_q;
    logic [W-1:0] row_d;
    logic         row_en;

    always_comb begin
      row_en = we && (wa == AW'(g));
      row_d  = wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (row_en) begin
        row_q <= row_d;
      end
    end

    assign ent[g] = row_q;
  end

  assign rd = ent[ra];
  assign pd = ent[pa][W-1 -: PW];

endmodule

// File: rtl/pcd_notice_seq.sv
module pcd_notice_seq #(
  parameter int NP = 4,
  localparam int PID_W = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NP-1:0]    load_mask,
  input  logic             rdy,
  output logic             valid,
  output logic [PID_W-1:0] proc
);

  logic [NP-1:0] mask_q;
  logic [NP-1:0] mask_d;

  always_comb begin
    proc = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (mask_q[i]) begin
        proc = PID_W'(i);
      end
    end
  end

  assign valid = |mask_q;

  always_comb begin
    mask_d = mask_q;
    if (load) begin
      mask_d = load_mask;
    end else if (valid && rdy) begin
      // drop the lowest pending target
      mask_d = mask_q & (mask_q - NP'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/pcd_engine.sv
module pcd_engine
  import pcd_pkg::*;
#(
  parameter int NPG = 8,
  parameter int NP  = 4,
  parameter int CW  = 4,
  localparam int PG_W  = (NPG > 1) ? $clog2(NPG) : 1,
  localparam int PID_W = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    notice_lim,
  input  logic [CW-1:0]    check_lim,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [1:0]       ev_kind,
  input  logic [PG_W-1:0]  ev_page,
  input  logic [PID_W-1:0] ev_proc,
  output logic             ntc_valid,
  input  logic             ntc_ready,
  output logic [PID_W-1:0] ntc_proc,
  output logic             chk_valid,
  output logic             chk_inval,
  input  logic [PG_W-1:0]  look_page,
  output logic [1:0]       look_base,
  output logic             look_unsafe,
  output logic [NP-1:0]    look_mappers
);

  localparam int ENT_W = 3 + 2 * NP + 2 * CW;
  localparam int PRB_W = 3 + NP;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rsync_q[1];

  logic [ENT_W-1:0] ent_rd;
  logic [ENT_W-1:0] ent_wr;
  logic [PRB_W-1:0] ent_pr;

  logic [1:0]    rd_base_b;
  pg_base_e      rd_base;
  logic          rd_uns;
  logic [NP-1:0] rd_sh;
  logic [NP-1:0] rd_wr;
  logic [CW-1:0] rd_nc;
  logic [CW-1:0] rd_cc;

  pg_base_e      nx_base;
  logic          nx_uns;
  logic [NP-1:0] nx_sh;
  logic [NP-1:0] nx_wr;
  logic [CW-1:0] nx_nc;
  logic [CW-1:0] nx_cc;
  logic [NP-1:0] nx_mask;
  logic          nx_inval;

  logic accept;
  logic busy;

  assign {rd_base_b, rd_uns, rd_sh, rd_wr, rd_nc, rd_cc} = ent_rd;
  assign rd_base = pg_base_e'(rd_base_b);
  assign ent_wr  = {2'(nx_base), nx_uns, nx_sh, nx_wr, nx_nc, nx_cc};

  pcd_table #(
    .DEPTH (NPG),
    .W     (ENT_W),
    .PW    (PRB_W)
  ) u_table (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (accept),
    .wa    (ev_page),
    .wd    (ent_wr),
    .ra    (ev_page),
    .rd    (ent_rd),
    .pa    (look_page),
    .pd    (ent_pr)
  );

  pcd_next #(
    .NP (NP),
    .CW (CW)
  ) u_next (
    .cur_base   (rd_base),
    .cur_unsafe (rd_uns),
    .cur_sh     (rd_sh),
    .cur_wr     (rd_wr),
    .cur_nc     (rd_nc),
    .cur_cc     (rd_cc),
    .kind       (ev_kind),
    .proc       (ev_proc),
    .nlim       (notice_lim),
    .clim       (check_lim),
    .nxt_base   (nx_base),
    .nxt_unsafe (nx_uns),
    .nxt_sh     (nx_sh),
    .nxt_wr     (nx_wr),
    .nxt_nc     (nx_nc),
    .nxt_cc     (nx_cc),
    .ntc_mask   (nx_mask),
    .acq_inval  (nx_inval)
  );

  pcd_notice_seq #(
    .NP (NP)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (accept),
    .load_mask (nx_mask),
    .rdy       (ntc_ready),
    .valid     (busy),
    .proc      (ntc_proc)
  );

  assign ntc_valid = busy;
  assign ev_ready  = rst_int_n & ~busy;
  assign accept    = ev_valid & ev_ready;

  // acquire response register
  logic chk_v_q, chk_v_d;
  logic chk_i_q, chk_i_d;

  always_comb begin
    chk_v_d = accept & ev_kind[1];
    chk_i_d = chk_v_d & nx_inval;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      chk_v_q <= 1'b0;
      chk_i_q <= 1'b0;
    end else begin
      chk_v_q <= chk_v_d;
      chk_i_q <= chk_i_d;
    end
  end

  assign chk_valid = chk_v_q;
  assign chk_inval = chk_i_q;

  assign look_base    = ent_pr[PRB_W-1 -: 2];
  assign look_unsafe  = ent_pr[PRB_W-3];
  assign look_mappers = ent_pr[NP-1:0];

endmodule

// File: rtl/pcd_engine_chk.sv
module pcd_engine_chk #(
  parameter int NP = 4,
  localparam int PID_W = (NP > 1) ? $clog2(NP) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic [1:0]       ev_kind,
  input logic             ntc_valid,
  input logic             ntc_ready,
  input logic [PID_W-1:0] ntc_proc,
  input logic             chk_valid,
  input logic             chk_inval
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!ntc_valid && !chk_valid && !ev_ready);
    end
  end

  // R11
  notice_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ntc_valid && !ntc_ready |=> ntc_valid && $stable(ntc_proc));

  // R4
  notice_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ntc_valid && ntc_ready |=> !ntc_valid || (ntc_proc > $past(ntc_proc)));

  // R4
  notice_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ntc_valid) |-> $past(ev_valid && ev_ready));

  // R8
  check_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> $past(ev_valid && ev_ready && ev_kind[1]));

  // R8
  check_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_inval |-> chk_valid);

endmodule

bind pcd_engine pcd_engine_chk #(.NP(NP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_valid  (ev_valid),
  .ev_ready  (ev_ready),
  .ev_kind   (ev_kind),
  .ntc_valid (ntc_valid),
  .ntc_ready (ntc_ready),
  .ntc_proc  (ntc_proc),
  .chk_valid (chk_valid),
  .chk_inval (chk_inval)
);

// File: tb/pcd_engine_test.sv
module pcd_engine_test;

  localparam int NPG = 8;
  localparam int NP  = 4;
  localparam int CW  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [3:0] notice_lim = 4'd2;
  logic [3:0] check_lim = 4'd2;
  logic       ev_valid = 1'b0;
  logic       ev_ready;
  logic [1:0] ev_kind = 2'd0;
  logic [2:0] ev_page = 3'd0;
  logic [1:0] ev_proc = 2'd0;
  logic       ntc_valid;
  logic       ntc_ready = 1'b1;
  logic [1:0] ntc_proc;
  logic       chk_valid;
  logic       chk_inval;
  logic [2:0] look_page = 3'd0;
  logic [1:0] look_base;
  logic       look_unsafe;
  logic [3:0] look_mappers;

  always #4 clk = ~clk;

  pcd_engine #(.NPG(NPG), .NP(NP), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .notice_lim(notice_lim), .check_lim(check_lim),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind), .ev_page(ev_page),
    .ev_proc(ev_proc), .ntc_valid(ntc_valid), .ntc_ready(ntc_ready), .ntc_proc(ntc_proc),
    .chk_valid(chk_valid), .chk_inval(chk_inval), .look_page(look_page),
    .look_base(look_base), .look_unsafe(look_unsafe), .look_mappers(look_mappers)
  );

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;
  bit cmp_en = 0;
  bit hold_look = 0;
  int rdy_mode = 0;

  // behavioural reference model
  int       m_base [NPG];
  bit       m_uns  [NPG];
  bit [3:0] m_sh   [NPG];
  bit [3:0] m_wr   [NPG];
  int       m_nc   [NPG];
  int       m_cc   [NPG];
  bit [3:0] m_pend;
  bit       m_chkv, m_chki;
  int       m_accepts = 0;
  int       seen_q [$];

  function automatic int lowest(bit [3:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic model_apply(int k, int pg, int pr);
    bit [3:0] b;
    int cnt;
    int nb;
    b = 4'b0001 << pr;
    if (k >= 2) begin
      m_chkv = 1;
      m_chki = (m_base[pg] == 3) && m_uns[pg];
      if (m_base[pg] == 3) begin
        m_sh[pg] &= ~b;
        m_wr[pg] &= ~b;
        if (m_sh[pg] == 0) begin m_base[pg] = 0; m_wr[pg] = 0; end
      end else if (m_uns[pg]) begin
        if (m_cc[pg] >= int'(check_lim)) begin m_uns[pg] = 0; m_cc[pg] = 0; end
        else m_cc[pg]++;
      end
    end else begin
      m_sh[pg] |= b;
      if (k == 1 && m_base[pg] != 0) m_wr[pg] |= b;
      cnt = $countones(m_sh[pg]);
      nb = (m_wr[pg] == 0) ? 1 : ((cnt == 1) ? 2 : 3);
      if (nb == 3 && m_base[pg] != 3 && !m_uns[pg]) begin
        if (m_nc[pg] >= int'(notice_lim)) begin m_uns[pg] = 1; m_nc[pg] = 0; end
        else begin m_pend = m_sh[pg] & ~b; m_nc[pg]++; end
      end
      m_base[pg] = nb;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPG; i++) begin
        m_base[i] = 0; m_uns[i] = 0; m_sh[i] = 0; m_wr[i] = 0; m_nc[i] = 0; m_cc[i] = 0;
      end
      m_pend = 0; m_chkv = 0; m_chki = 0;
    end else begin
      m_chkv = 0;
      m_chki = 0;
      if (m_pend != 0) begin
        if (ntc_ready) m_pend[lowest(m_pend)] = 1'b0;
      end else if (ev_valid && cmp_en) begin
        m_accepts++;
        model_apply(int'(ev_kind), int'(ev_page), int'(ev_proc));
      end
    end
  end

  always @(posedge clk) if (ntc_valid && ntc_ready) seen_q.push_back(int'(ntc_proc));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check(32'(ev_ready), 32'(m_pend == 0), "R5 ev_ready");
      check(32'(ntc_valid), 32'(m_pend != 0), "R4 ntc_valid");
      if (m_pend != 0) check(32'(ntc_proc), 32'(lowest(m_pend)), "R11 ntc_proc");
      check(32'(chk_valid), 32'(m_chkv), "R8 chk_valid");
      if (m_chkv) check(32'(chk_inval), 32'(m_chki), "R8 chk_inval");
      check(32'(look_base), 32'(m_base[look_page]), "R2 look_base");
      check(32'(look_unsafe), 32'(m_uns[look_page]), "R6 look_unsafe");
      check(32'(look_mappers), 32'(m_sh[look_page]), "R9 look_mappers");
    end
  end

  always @(negedge clk) begin
    #1;
    case (rdy_mode)
      0: ntc_ready = 1'b1;
      1: ntc_ready = 1'($urandom % 2);
      default: ntc_ready = 1'b0;
    endcase
    #1;
    if (!hold_look) look_page = look_page + 3'd1;
  end

  task automatic do_ev(input int k, input int pg, input int pr);
    int c0;
    @(negedge clk); #3;
    c0 = m_accepts;
    ev_kind = 2'(k); ev_page = 3'(pg); ev_proc = 2'(pr); ev_valid = 1'b1;
    do @(negedge clk); while (m_accepts == c0);
    #3 ev_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!ev_ready) @(negedge clk);
    #3;
  endtask

  task automatic peek(input int pg, input int base, input int uns, input string tag);
    hold_look = 1;
    look_page = 3'(pg);
    #1;
    check(32'(look_base), 32'(base), {tag, " base"});
    check(32'(look_unsafe), 32'(uns), {tag, " unsafe"});
    hold_look = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    // R1: idle ports and empty directory
    check(32'(ev_ready), 1, "R1 ev_ready");
    check(32'(ntc_valid), 0, "R1 ntc_valid");
    check(32'(chk_valid), 0, "R1 chk_valid");
    for (int p = 0; p < NPG; p++) begin
      peek(p, 0, 0, "R1");
      check(32'(look_mappers), 0, "R1 mappers");
    end
    cmp_en = 1;

    // round 1: safe page, notices to the readers (R2, R4, R9)
    do_ev(0, 1, 1); peek(1, 1, 0, "R2 read");
    do_ev(0, 1, 2); peek(1, 1, 0, "R2 two readers");
    seen_q.delete();
    do_ev(1, 1, 0);
    wait_idle();
    check(32'(seen_q.size()), 2, "R4 notice count");
    if (seen_q.size() == 2) begin
      check(32'(seen_q[0]), 1, "R4 first target");
      check(32'(seen_q[1]), 2, "R4 second target");
    end
    peek(1, 3, 0, "R2 weak");
    do_ev(2, 1, 0); check(32'(chk_inval), 0, "R8 safe keep");
    peek(1, 3, 0, "R9 stays weak");
    do_ev(2, 1, 1);
    do_ev(2, 1, 2); peek(1, 0, 0, "R9 emptied");

    // round 2: back-pressured notices (R5, R11)
    do_ev(0, 1, 1);
    do_ev(0, 1, 2);
    seen_q.delete();
    rdy_mode = 2;
    do_ev(1, 1, 0);
    repeat (3) begin
      @(negedge clk); #3;
      check(32'(ev_ready), 0, "R5 blocked");
      check(32'(ntc_valid), 1, "R11 valid held");
      check(32'(ntc_proc), 1, "R11 target held");
    end
    rdy_mode = 0;
    wait_idle();
    check(32'(seen_q.size()), 2, "R4 notices after stall");
    do_ev(2, 1, 0); do_ev(2, 1, 1); do_ev(2, 1, 2);

    // round 3: limit reached, page turns unsafe (R6, R8)
    do_ev(0, 1, 1);
    do_ev(0, 1, 2);
    seen_q.delete();
    do_ev(1, 1, 0);
    wait_idle();
    check(32'(seen_q.size()), 0, "R6 no notices");
    peek(1, 3, 1, "R6 unsafe weak");
    do_ev(2, 1, 0);
    check(32'(chk_valid), 1, "R8 response");
    check(32'(chk_inval), 1, "R8 invalidate");
    do_ev(2, 1, 1); check(32'(chk_inval), 1, "R8 invalidate 2");
    do_ev(2, 1, 2); peek(1, 0, 1, "R9 unsafe emptied");

    // round 4: unsafe page goes weak silently (R7)
    do_ev(0, 1, 1);
    do_ev(0, 1, 2);
    seen_q.delete();
    do_ev(1, 1, 0);
    wait_idle();
    check(32'(seen_q.size()), 0, "R7 no notices");
    peek(1, 3, 1, "R7 weak unsafe");
    do_ev(2, 1, 0); do_ev(2, 1, 1); do_ev(2, 1, 2);

    // unneeded checks relax the page (R10)
    do_ev(2, 1, 3); check(32'(chk_inval), 0, "R10 keep"); peek(1, 0, 1, "R10 one check");
    do_ev(2, 1, 3); peek(1, 0, 1, "R10 two checks");
    do_ev(2, 1, 3); peek(1, 0, 0, "R10 back to safe");

    // deferred write on an unmapped page (R3)
    do_ev(1, 2, 3); peek(2, 1, 0, "R3 shared");
    hold_look = 1; look_page = 3'd2; #1;
    check(32'(look_mappers), 8, "R3 mapper recorded");
    hold_look = 0;
    do_ev(1, 2, 3); peek(2, 2, 0, "R2 dirty");
    seen_q.delete();
    do_ev(0, 2, 0);
    wait_idle();
    peek(2, 3, 0, "R2 reader joins writer");
    check(32'(seen_q.size()), 1, "R4 single notice");
    if (seen_q.size() == 1) check(32'(seen_q[0]), 3, "R4 writer notified");

    // random traffic against the model
    rdy_mode = 1;
    for (int i = 0; i < 2500; i++) begin
      do_ev(int'($urandom % 4), int'($urandom % NPG), int'($urandom % NP));
      if (i == 1200) begin
        wait_idle();
        notice_lim = 4'd3;
        check_lim = 4'd1;
      end
    end
    rdy_mode = 0;
    wait_idle();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule